// File: doc/BRIEF.md
# Supply Supervisor with Battery Check

This block watches three digitised supply comparators and sets the access state of a battery-backed memory and clock. When the main supply drops below the deselect threshold, the memory is cut off at once. The external chip-enable is overridden, the data outputs are disabled, and a write in progress ends. The memory stays protected until the supply has been good for a programmable number of microseconds. It then leaves protection and sends a one-cycle reset pulse to the clock's access-control bits.

A separate comparator output steers the power source to the battery. A third comparator reports whether the battery voltage is good. The block samples it when access is regained after power-up and again at a fixed interval while the supply stays good. It keeps the result in a sticky low-battery flag.

All comparator inputs are asynchronous and pass through two-flop synchronisers. The time base is a one-cycle microsecond tick. Seconds are derived from that tick, and the check interval is counted in seconds.

Top module: `pwr_guard`

## Requirements
- R1: During and directly after reset the block is protected: `out_dis_o`=1, `ce_gate_n_o`=1, `bat_sel_o`=1, `batt_low_o`=0 and `por_clr_o`=0.
- R2: A falling `vcc_ok_i` forces `ce_gate_n_o`=1 and `out_dis_o`=1 no later than the third rising clock edge after the change, even when `ce_n_i` is low, so a write in progress is cut off.
- R3: While protected, `ce_gate_n_o` stays 1 whatever `ce_n_i` does.
- R4: `bat_sel_o` is the inverse of `vcc_so_i` after the two-flop synchroniser (1 = battery supplies the core).
- R5: After `vcc_ok_i` rises, protection lasts until REC_US microsecond ticks have been seen with the supply good. A drop during that wait restarts the count from zero.
- R6: Outside protection, `ce_gate_n_o` equals `ce_n_i` and `out_dis_o`=0.
- R7: `por_clr_o` is high for exactly one cycle, the first cycle after protection ends, once per power-up.
- R8: In the cycle that protection ends, the battery is checked: `batt_low_o` becomes 1 if the synchronised `batt_ok_i` is 0, else 0.
- R9: While unprotected, the battery is checked again every DAY_SEC seconds of US_PER_SEC ticks each. Between checks `batt_low_o` keeps its value whatever `batt_ok_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| vcc_ok_i | input | 1 | Supply above deselect threshold (asynchronous) |
| vcc_so_i | input | 1 | Supply above battery switchover threshold (asynchronous) |
| batt_ok_i | input | 1 | Battery above low-voltage limit (asynchronous) |
| ce_n_i | input | 1 | External chip enable, active low |
| ce_gate_n_o | output | 1 | Gated chip enable to the memory, active low |
| out_dis_o | output | 1 | Data output disable, 1 = high impedance |
| bat_sel_o | output | 1 | 1 = battery powers the core |
| por_clr_o | output | 1 | One-cycle clear for clock read/write control bits |
| batt_low_o | output | 1 | Sticky low-battery flag |

## Verification
The bench builds the block with REC_US=5, US_PER_SEC=3 and DAY_SEC=4, and drives a tick every four clocks. A whole recovery window then lasts about twenty cycles and a periodic battery check comes 48 cycles after access resumes. This brings the restart of the recovery count after a dip and the sticky flag across two periodic checks within a short run. The bench aligns to the reset pulse, so it can sample the flag on known cycles just before and just after a check.

// File: rtl/pg_pkg.sv
package pg_pkg;
    typedef enum logic [1:0] {
        PG_DOWN    = 2'd0,
        PG_RECOVER = 2'd1,
        PG_ACTIVE  = 2'd2
    } pg_state_e;

    typedef struct packed {
        logic batt_ok;
        logic vcc_so;
        logic vcc_ok;
    } pg_cmp_t;

    localparam int PG_CMP_N = $bits(pg_cmp_t);

    function automatic int pg_cw(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d_i[g];
                s2 <= s1;
            end
        end
        assign q_o[g] = s2;
    end
endmodule

// File: rtl/pg_seq.sv
module pg_seq
    import pg_pkg::*;
#(
    parameter int REC_US = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic us_tick,
    input  logic vcc_ok_s,
    output logic protect_o,
    output logic pwr_up_o
);
    localparam int REC_W = pg_cw(REC_US);

    pg_state_e        st;
    logic [REC_W-1:0] cnt;
    logic             pup_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= PG_DOWN;
            cnt   <= '0;
            pup_q <= 1'b0;
        end else begin
            pup_q <= 1'b0;
            case (st)
                PG_DOWN: begin
                    cnt <= '0;
                    if (vcc_ok_s) st <= PG_RECOVER;
                end
                PG_RECOVER: begin
                    if (!vcc_ok_s) begin
                        st  <= PG_DOWN;
                        cnt <= '0;
                    end else if (us_tick) begin
                        if (cnt == REC_W'(REC_US - 1)) begin
                            st    <= PG_ACTIVE;
                            cnt   <= '0;
                            pup_q <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PG_ACTIVE: begin
                    if (!vcc_ok_s) st <= PG_DOWN;
                end
                default: st <= PG_DOWN;
            endcase
        end
    end

    assign protect_o = (st != PG_ACTIVE);
    assign pwr_up_o  = pup_q;

    // R2
    prot_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !vcc_ok_s |=> protect_o);

    // R5
    rec_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) < REC_US);

    // R7
    por_single_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_up_o |=> !pwr_up_o);
endmodule

// File: rtl/pg_batmon.sv
module pg_batmon
    import pg_pkg::*;
#(
    parameter int US_PER_SEC = 1000000,
    parameter int DAY_SEC    = 86400
) (
    input  logic clk,
    input  logic rst,
    input  logic us_tick,
    input  logic active_i,
    input  logic pwr_up_i,
    input  logic batt_ok_s,
    output logic batt_low_o
);
    localparam int US_W  = pg_cw(US_PER_SEC);
    localparam int SEC_W = pg_cw(DAY_SEC);

    logic [US_W-1:0]  us_cnt;
    logic [SEC_W-1:0] sec_cnt;
    logic             sec_end, day_end, check;
    logic             flag_q;

    assign sec_end = us_tick && (us_cnt == US_W'(US_PER_SEC - 1));
    assign day_end = active_i && sec_end && (sec_cnt == SEC_W'(DAY_SEC - 1));
    assign check   = pwr_up_i || day_end;

    always_ff @(posedge clk) begin
        if (rst || !active_i || pwr_up_i) begin
            us_cnt  <= '0;
            sec_cnt <= '0;
        end else if (us_tick) begin
            if (sec_end) begin
                us_cnt  <= '0;
                sec_cnt <= day_end ? '0 : sec_cnt + 1'b1;
            end else begin
                us_cnt <= us_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (check) flag_q <= !batt_ok_s;
    end

    assign batt_low_o = flag_q;

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !check |=> $stable(batt_low_o));
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
    import pg_pkg::*;
#(
    parameter int REC_US     = 100,
    parameter int US_PER_SEC = 1000000,
    parameter int DAY_SEC    = 86400
) (
    input  logic clk,
    input  logic rst,
    input  logic us_tick,
    input  logic vcc_ok_i,
    input  logic vcc_so_i,
    input  logic batt_ok_i,
    input  logic ce_n_i,
    output logic ce_gate_n_o,
    output logic out_dis_o,
    output logic bat_sel_o,
    output logic por_clr_o,
    output logic batt_low_o
);
    pg_cmp_t raw, syn;
    logic    protect, pwr_up;

    assign raw.vcc_ok  = vcc_ok_i;
    assign raw.vcc_so  = vcc_so_i;
    assign raw.batt_ok = batt_ok_i;

    pg_sync #(.WIDTH(PG_CMP_N)) u_sync (
        .clk(clk), .rst(rst), .d_i(raw), .q_o(syn)
    );

    pg_seq #(.REC_US(REC_US)) u_seq (
        .clk(clk), .rst(rst), .us_tick(us_tick), .vcc_ok_s(syn.vcc_ok),
        .protect_o(protect), .pwr_up_o(pwr_up)
    );

    pg_batmon #(.US_PER_SEC(US_PER_SEC), .DAY_SEC(DAY_SEC)) u_bat (
        .clk(clk), .rst(rst), .us_tick(us_tick), .active_i(!protect),
        .pwr_up_i(pwr_up), .batt_ok_s(syn.batt_ok), .batt_low_o(batt_low_o)
    );

    assign ce_gate_n_o = ce_n_i | protect;
    assign out_dis_o   = protect;
    assign bat_sel_o   = !syn.vcc_so;
    assign por_clr_o   = pwr_up;

    // R7
    por_edge_chk: assert property (@(posedge clk) disable iff (rst)
        por_clr_o |-> (!out_dis_o && $past(out_dis_o)));
endmodule

// File: tb/sim_pwr_guard.sv
module sim_pwr_guard;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic us_tick = 1'b0;
    logic vcc_ok = 1'b0, vcc_so = 1'b0, batt_ok = 1'b1, ce_n = 1'b0;
    logic ce_gate_n, out_dis, bat_sel, por_clr, batt_low;
    int   n_chk = 0, n_bad = 0, por_cnt = 0;

    always #5 clk = ~clk;

    pwr_guard #(.REC_US(5), .US_PER_SEC(3), .DAY_SEC(4)) u0 (
        .clk(clk), .rst(rst), .us_tick(us_tick), .vcc_ok_i(vcc_ok),
        .vcc_so_i(vcc_so), .batt_ok_i(batt_ok), .ce_n_i(ce_n),
        .ce_gate_n_o(ce_gate_n), .out_dis_o(out_dis), .bat_sel_o(bat_sel),
        .por_clr_o(por_clr), .batt_low_o(batt_low)
    );

    // tick: one cycle high in every four
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            us_tick = (ph == 3);
            ph = (ph + 1) % 4;
        end
    end

    initial forever begin
        @(negedge clk);
        if (por_clr) por_cnt++;
    end

    // {vcc_ok, vcc_so, ce_n, exp_gate_n, exp_dis, exp_bat}
    localparam logic [5:0] VEC [6] = '{
        6'b110_000, 6'b111_100, 6'b010_110,
        6'b000_111, 6'b001_111, 6'b110_000
    };

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_por();
        int k = 0;
        @(negedge clk);
        while (!por_clr && k < 200) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int p0;
        // R1 reset state
        cyc(4);
        chk(out_dis, 1'b1, "R1 out_dis");
        chk(ce_gate_n, 1'b1, "R1 ce_gate");
        chk(bat_sel, 1'b1, "R1 bat_sel");
        chk(batt_low, 1'b0, "R1 batt_low");
        chk(por_clr, 1'b0, "R1 por");
        rst = 1'b0;
        cyc(1);
        chk(out_dis, 1'b1, "R1 out_dis after release");

        // steady-state table: R3 R4 R6
        foreach (VEC[i]) begin
            {vcc_ok, vcc_so, ce_n} = VEC[i][5:3];
            cyc(40);
            chk(ce_gate_n, VEC[i][2], "R6/R3 table ce_gate");
            chk(out_dis, VEC[i][1], "R6/R3 table out_dis");
            chk(bat_sel, VEC[i][0], "R4 table bat_sel");
        end
        chk(por_cnt == 2, 1'b1, "R7 one pulse per power-up");

        // R2: cutoff of an active write
        ce_n = 1'b0;
        chk(ce_gate_n, 1'b0, "R6 active write");
        vcc_ok = 1'b0;
        cyc(3);
        chk(ce_gate_n, 1'b1, "R2 cutoff ce_gate");
        chk(out_dis, 1'b1, "R2 cutoff out_dis");

        // R3: ce ignored while protected
        ce_n = 1'b1; cyc(2);
        chk(ce_gate_n, 1'b1, "R3 ce high");
        ce_n = 1'b0; cyc(2);
        chk(ce_gate_n, 1'b1, "R3 ce low");

        // R5: recovery window
        p0 = por_cnt;
        vcc_ok = 1'b1;
        cyc(12);
        chk(out_dis, 1'b1, "R5 still protected");
        cyc(28);
        chk(out_dis, 1'b0, "R5 released");
        chk(por_cnt == p0 + 1, 1'b1, "R7 pulse after recovery");

        // R5: dip during recovery restarts count
        vcc_ok = 1'b0; cyc(10);
        p0 = por_cnt;
        vcc_ok = 1'b1; cyc(10);
        vcc_ok = 1'b0; cyc(5);
        vcc_ok = 1'b1; cyc(14);
        chk(out_dis, 1'b1, "R5 restart after dip");
        cyc(30);
        chk(out_dis, 1'b0, "R5 released after dip");
        chk(por_cnt == p0 + 1, 1'b1, "R7 single pulse after dip");

        // R7 and R9: sticky flag across periodic checks
        vcc_ok = 1'b0; cyc(10);
        vcc_ok = 1'b1;
        wait_por();
        chk(por_clr, 1'b1, "R7 pulse seen");
        cyc(1);
        chk(por_clr, 1'b0, "R7 pulse one cycle");
        chk(batt_low, 1'b0, "R8 good battery at power-up");
        cyc(4);
        batt_ok = 1'b0;
        cyc(35);
        chk(batt_low, 1'b0, "R9 flag held before check");
        cyc(15);
        chk(batt_low, 1'b1, "R9 periodic check sets flag");
        cyc(5);
        batt_ok = 1'b1;
        cyc(30);
        chk(batt_low, 1'b1, "R9 flag sticky");
        cyc(10);
        chk(batt_low, 1'b0, "R9 periodic check clears flag");

        // R8: bad battery at power-up
        vcc_ok = 1'b0; batt_ok = 1'b0; cyc(10);
        vcc_ok = 1'b1;
        wait_por();
        cyc(3);
        chk(batt_low, 1'b1, "R8 bad battery at power-up");

        finish_run();
    end
endmodule